// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a slave-side serial port that gives an external controller read and write access to a bank of 8-bit configuration and status registers. A transfer runs while the active-low select is held low. It carries an 8-bit address and then 8 data bits on one shared data line, most significant bit first. A separate direction pin chooses read or write for the whole transfer. The shared line is brought to the block as an input, an output and an output enable, so that the pad cell stays outside the block.

The serial clock has no fixed relation to the system clock and runs at no more than half its rate. All shifting happens in the serial clock domain. A completed write is handed to the system clock domain as a toggle, which passes through a two-flop synchronizer and an edge detector before it updates the register bank. The register bank has three parts. The low indices are writable configuration bytes, presented in parallel on `cfg_o`. Above them sits a window of read-only status bytes taken from `stat_i`. Register indices above the bank read as zero. Reset clears the transfer logic and leaves the stored register contents untouched.

Top module: `cfgp_top`

## Requirements
- R1: A write frame is 8 address bits followed by 8 data bits, both MSB first, sampled on rising `sclk` edges. It stores the data byte at register index `addr[7:1]` once the 16th rising edge has occurred.
- R2: Address bit 0 is ignored: addresses 2k and 2k+1 reach the same register.
- R3: When `rw` is high the transfer is a read. The 8th rising edge places bit 7 of the addressed register on `sdio_o`, and each of the next seven rising edges places the next lower bit. A read never modifies any register.
- R4: `sdio_oe` is high only while `cs_n` is low, `rw` is high and between 8 and 15 rising edges have been seen; at all other times it is low.
- R5: Raising `cs_n` abandons a transfer at once. A frame cut short before its 16th edge writes nothing, `sclk` activity while `cs_n` is high has no effect, and the next transfer starts with a fresh address phase.
- R6: Indices `NUM_REGS-RO_REGS` up to `NUM_REGS-1` are read-only. Writes to them are discarded, and reads of index `NUM_REGS-RO_REGS+j` return `stat_i[8j+7:8j]`.
- R7: Indices at or above `NUM_REGS` hold nothing. Writes to them are discarded and reads of them return 0.
- R8: Asserting `rst_n` does not change the contents of the writable registers.
- R9: Writable register i appears on `cfg_o[8i+7:8i]`, updated within 4 system clock cycles after the 16th rising `sclk` edge of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control logic |
| sclk | input | 1 | Serial port clock, asynchronous to `clk` |
| cs_n | input | 1 | Active-low select; high resets the transfer state |
| rw | input | 1 | Direction: 1 = read, 0 = write |
| sdio_i | input | 1 | Serial data from the shared line |
| sdio_o | output | 1 | Serial read data toward the shared line |
| sdio_oe | output | 1 | Drive enable for the shared line |
| stat_i | input | 8*RO_REGS | Read-only status bytes |
| cfg_o | output | 8*(NUM_REGS-RO_REGS) | Writable register contents |

## Verification
Write and read frames are run with the data patterns 0x5A, 0xA5, 0x00 and 0xFF. A shifted or reversed data path shows up on the alternating values, and a stuck bit shows up on the all-zero and all-one values. The lowest and highest writable indices, the first and last status indices, and indices beyond the bank exercise the region decode. Pairs of addresses that differ only in bit 0 show whether that bit is dropped. A frame cut short by `cs_n`, stray `sclk` pulses while deselected, and a reset pulse after a write each separate a correct port from one that commits early, counts stray clocks, or clears stored data. The output-enable trace of each frame pins down on exactly which edges the line is driven.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = ADDR_W + DATA_W;
    localparam int IDX_W      = ADDR_W - 1;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_BITS-2:0] sh;
        logic [DATA_W-1:0]     out;
    } shf_t;

    typedef struct packed {
        logic              tog;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] dat;
    } wcap_t;
endpackage

// File: rtl/cfgp_shifter.sv
module cfgp_shifter
    import cfgp_pkg::*;
(
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              rst_n,
    input  logic              rw,
    input  logic              sdio_i,
    input  logic [DATA_W-1:0] rd_byte,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic              wr_tog,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_dat
);
    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] DONE      = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] DATA_BEG  = CNT_W'(ADDR_W);

    shf_t  s_d, s_q;
    wcap_t w_d, w_q;

    // Next state of the frame shifter and the write capture
    always_comb begin
        s_d = s_q;
        w_d = w_q;
        if (s_q.cnt != DONE) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        s_d.sh = {s_q.sh[FRAME_BITS-3:0], sdio_i};
        if (s_q.cnt == LAST_ADDR) begin
            s_d.out = rd_byte;
        end else begin
            s_d.out = {s_q.out[DATA_W-2:0], 1'b0};
        end
        if (s_q.cnt == LAST_BIT && !rw) begin
            w_d.tog = ~w_q.tog;
            w_d.idx = s_q.sh[FRAME_BITS-2 -: IDX_W];
            w_d.dat = {s_q.sh[DATA_W-2:0], sdio_i};
        end
    end

    always_ff @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else if (!cs_n) begin
            w_q <= w_d;
        end
    end

    // After 7 shifts the low bits hold addr[7:1]
    assign rd_idx  = s_q.sh[IDX_W-1:0];
    assign sdio_o  = s_q.out[DATA_W-1];
    assign sdio_oe = !cs_n && rw && (s_q.cnt >= DATA_BEG) && (s_q.cnt < DONE);
    assign wr_tog  = w_q.tog;
    assign wr_idx  = w_q.idx;
    assign wr_dat  = w_q.dat;
endmodule

// File: rtl/cfgp_regbank.sv
module cfgp_regbank
    import cfgp_pkg::*;
#(
    parameter int NUM_REGS = 96,
    parameter int RO_REGS  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_tog,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_dat,
    input  logic [IDX_W-1:0]             rd_idx,
    output logic [DATA_W-1:0]            rd_byte,
    input  logic [DATA_W*RO_REGS-1:0]    stat_i,
    output logic [DATA_W*(NUM_REGS-RO_REGS)-1:0] cfg_o
);
    localparam int RW_REGS = NUM_REGS - RO_REGS;
    localparam int RW_AW   = (RW_REGS > 1) ? $clog2(RW_REGS) : 1;
    localparam int ST_W    = (RO_REGS > 1) ? $clog2(RO_REGS) : 1;
    localparam int SYNC_N  = 3;

    logic [SYNC_N-1:0] sync_d, sync_q;
    logic              wr_pulse;
    logic              wr_ok;
    logic [DATA_W-1:0] regs_d [RW_REGS];
    logic [DATA_W-1:0] regs_q [RW_REGS];
    logic [DATA_W-1:0] stat_a [RO_REGS];
    logic [ST_W-1:0]   st_sel;

    // Two synchronizing flops plus one history flop for the edge detect
    always_comb begin
        sync_d   = {sync_q[SYNC_N-2:0], wr_tog};
        wr_pulse = sync_q[SYNC_N-1] ^ sync_q[SYNC_N-2];
        wr_ok    = int'(wr_idx) < RW_REGS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    always_comb begin
        regs_d = regs_q;
        if (wr_pulse && wr_ok) begin
            regs_d[RW_AW'(wr_idx)] = wr_dat;
        end
    end

    // Contents are kept through reset
    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    for (genvar g = 0; g < RW_REGS; g++) begin : g_cfg
        assign cfg_o[DATA_W*g +: DATA_W] = regs_q[g];
    end

    for (genvar g = 0; g < RO_REGS; g++) begin : g_stat
        assign stat_a[g] = stat_i[DATA_W*g +: DATA_W];
    end

    assign st_sel = ST_W'(int'(rd_idx) - RW_REGS);

    // Read byte, sampled by the serial domain at the end of the address
    always_comb begin
        if (int'(rd_idx) < RW_REGS) begin
            rd_byte = regs_q[RW_AW'(rd_idx)];
        end else if (int'(rd_idx) < NUM_REGS) begin
            rd_byte = stat_a[st_sel];
        end else begin
            rd_byte = '0;
        end
    end

    // R1
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    // R1
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && wr_ok) |=> (regs_q[RW_AW'(wr_idx)] == $past(wr_dat)));

    // R6 R7
    ro_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && !wr_ok) |=> $stable(cfg_o));

    // R3 R5
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pulse |=> $stable(cfg_o));
endmodule

// File: rtl/cfgp_top.sv
module cfgp_top
    import cfgp_pkg::*;
#(
    parameter int NUM_REGS = 96,
    parameter int RO_REGS  = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 sclk,
    input  logic                                 cs_n,
    input  logic                                 rw,
    input  logic                                 sdio_i,
    output logic                                 sdio_o,
    output logic                                 sdio_oe,
    input  logic [DATA_W*RO_REGS-1:0]            stat_i,
    output logic [DATA_W*(NUM_REGS-RO_REGS)-1:0] cfg_o
);
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_byte;
    logic              wr_tog;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_dat;

    cfgp_shifter u_shf (
        .sclk    (sclk),
        .cs_n    (cs_n),
        .rst_n   (rst_n),
        .rw      (rw),
        .sdio_i  (sdio_i),
        .rd_byte (rd_byte),
        .rd_idx  (rd_idx),
        .sdio_o  (sdio_o),
        .sdio_oe (sdio_oe),
        .wr_tog  (wr_tog),
        .wr_idx  (wr_idx),
        .wr_dat  (wr_dat)
    );

    cfgp_regbank #(
        .NUM_REGS (NUM_REGS),
        .RO_REGS  (RO_REGS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_tog  (wr_tog),
        .wr_idx  (wr_idx),
        .wr_dat  (wr_dat),
        .rd_idx  (rd_idx),
        .rd_byte (rd_byte),
        .stat_i  (stat_i),
        .cfg_o   (cfg_o)
    );

    // R4
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sdio_oe);
endmodule

// File: tb/cfgp_top_tb_top.sv
module cfgp_top_tb_top;
    localparam int NREG = 96;
    localparam int NRO  = 16;
    localparam int NRW  = NREG - NRO;
    localparam int HALF = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic rw = 1'b0;
    logic sdio_i = 1'b0;
    logic sdio_o, sdio_oe;
    logic [8*NRO-1:0] stat_i;
    logic [8*NRW-1:0] cfg_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cfgp_top #(.NUM_REGS(NREG), .RO_REGS(NRO)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .rw(rw),
        .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe),
        .stat_i(stat_i), .cfg_o(cfg_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One frame of nbits rising edges; oem[i] is the enable after edge i+1
    task automatic xfer(input logic rd, input logic [7:0] a, input logic [7:0] wd,
                        input int nbits, output logic [7:0] rdat, output logic [15:0] oem);
        rdat = '0;
        oem  = '0;
        rw   = rd;
        #10 cs_n = 1'b0;
        #10;
        for (int i = 0; i < nbits; i++) begin
            sdio_i = (i < 8) ? a[7-i] : wd[15-i];
            #HALF sclk = 1'b1;
            #HALF sclk = 1'b0;
            oem[i] = sdio_oe;
            if (i >= 7 && i <= 14) rdat[14-i] = sdio_o;
        end
        #HALF cs_n = 1'b1;
        sdio_i = 1'b0;
        #100;
    endtask

    function automatic logic [7:0] cfg_at(input int idx);
        return cfg_o[8*idx +: 8];
    endfunction

    task automatic t_reset();
        check("R4 reset oe", {31'd0, sdio_oe}, 32'd0);
    endtask

    task automatic t_write_read();
        logic [7:0] r;
        logic [15:0] m;
        logic [7:0] vals [4] = '{8'h5A, 8'hA5, 8'h00, 8'hFF};
        int idxs [4] = '{0, 7, 42, NRW-1};
        for (int k = 0; k < 4; k++) begin
            xfer(1'b0, 8'(idxs[k] * 2), vals[k], 16, r, m);
            check("R9 cfg_o after write", {24'd0, cfg_at(idxs[k])}, {24'd0, vals[k]});
            check("R4 oe during write", {16'd0, m}, 32'd0);
        end
        for (int k = 0; k < 4; k++) begin
            xfer(1'b1, 8'(idxs[k] * 2), 8'h00, 16, r, m);
            check("R1 R3 readback", {24'd0, r}, {24'd0, vals[k]});
            check("R4 oe during read", {16'd0, m}, 32'h7F80);
        end
    endtask

    task automatic t_lsb();
        logic [7:0] r;
        logic [15:0] m;
        xfer(1'b0, 8'h21, 8'h3C, 16, r, m);
        check("R2 odd addr write", {24'd0, cfg_at(16)}, 32'h3C);
        xfer(1'b1, 8'h20, 8'h00, 16, r, m);
        check("R2 even addr read", {24'd0, r}, 32'h3C);
        xfer(1'b1, 8'h21, 8'h00, 16, r, m);
        check("R2 odd addr read", {24'd0, r}, 32'h3C);
    endtask

    task automatic t_read_only();
        logic [7:0] r;
        logic [15:0] m;
        logic [8*NRW-1:0] snap;
        snap = cfg_o;
        xfer(1'b0, 8'(NRW * 2), 8'h77, 16, r, m);
        xfer(1'b0, 8'((NREG - 1) * 2), 8'h77, 16, r, m);
        check("R6 ro write discarded", {31'd0, cfg_o == snap}, 32'd1);
        xfer(1'b1, 8'(NRW * 2), 8'h00, 16, r, m);
        check("R6 first status byte", {24'd0, r}, {24'd0, stat_i[7:0]});
        xfer(1'b1, 8'((NREG - 1) * 2 + 1), 8'h00, 16, r, m);
        check("R6 last status byte", {24'd0, r}, {24'd0, stat_i[8*NRO-1 -: 8]});
    endtask

    task automatic t_out_of_range();
        logic [7:0] r;
        logic [15:0] m;
        logic [8*NRW-1:0] snap;
        snap = cfg_o;
        xfer(1'b0, 8'(NREG * 2), 8'hEE, 16, r, m);
        xfer(1'b0, 8'hFE, 8'hEE, 16, r, m);
        check("R7 oob write discarded", {31'd0, cfg_o == snap}, 32'd1);
        xfer(1'b1, 8'(NREG * 2), 8'h00, 16, r, m);
        check("R7 oob read zero", {24'd0, r}, 32'd0);
        xfer(1'b1, 8'hFF, 8'h00, 16, r, m);
        check("R7 top read zero", {24'd0, r}, 32'd0);
    endtask

    task automatic t_abort();
        logic [7:0] r;
        logic [15:0] m;
        xfer(1'b0, 8'h0A, 8'h11, 16, r, m);
        xfer(1'b0, 8'h0A, 8'hAA, 12, r, m);
        check("R5 short frame no write", {24'd0, cfg_at(5)}, 32'h11);
        rw = 1'b0;
        for (int i = 0; i < 5; i++) begin
            sdio_i = 1'b1;
            #HALF sclk = 1'b1;
            #HALF sclk = 1'b0;
        end
        sdio_i = 1'b0;
        #100;
        check("R5 deselected clocks ignored", {24'd0, cfg_at(5)}, 32'h11);
        xfer(1'b0, 8'h0A, 8'hC3, 16, r, m);
        check("R5 fresh frame after abort", {24'd0, cfg_at(5)}, 32'hC3);
        xfer(1'b1, 8'h0A, 8'h00, 16, r, m);
        check("R3 read leaves reg", {24'd0, cfg_at(5)}, 32'hC3);
        check("R3 read value", {24'd0, r}, 32'hC3);
    endtask

    task automatic t_reset_keeps();
        logic [7:0] r;
        logic [15:0] m;
        xfer(1'b0, 8'h50, 8'h96, 16, r, m);
        #7 rst_n = 1'b0;
        #40 rst_n = 1'b1;
        #40;
        check("R8 reg kept through reset", {24'd0, cfg_at(40)}, 32'h96);
        xfer(1'b1, 8'h50, 8'h00, 16, r, m);
        check("R8 readback after reset", {24'd0, r}, 32'h96);
    endtask

    initial begin
        for (int j = 0; j < NRO; j++) stat_i[8*j +: 8] = 8'(8'h30 + j * 7);
        #41 rst_n = 1'b1;
        #40;
        t_reset();
        t_write_read();
        t_lsb();
        t_read_only();
        t_out_of_range();
        t_abort();
        t_reset_keeps();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule